// File: doc/BRIEF.md
# Program Memory Read-Limit Guard

This block sits on the path between a processor's code-memory port and the flash array. It splits the 16-bit code space at a limit address built from an 8-bit security byte. Addresses at or above the limit form the upper partition; addresses below it form the lower, protected partition. Code running in the upper partition may call into and execute lower-partition code. When that code issues a table read (a data read of code memory) from the lower partition, it gets zero instead of the stored byte.

The guard classifies both the requester and the target when the table-read strobe is high. The requester is identified by the address of the executing instruction. The guard carries that decision alongside the flash read. It then either passes the flash byte through or replaces it with 0x00 in the return cycle, and pulses a violation flag at the same time. Instruction fetches always pass. Flash data returns a fixed `RD_LAT` cycles after the strobe (default 1), and the guard adds no latency of its own.

Top module: `code_read_guard`

## Requirements
- R1: The limit address is {sec_limit, 8'h00}. An address is in the upper partition exactly when its bits [15:8] are greater than or equal to sec_limit, so the boundary moves in 256-byte steps.
- R2: The limit address itself belongs to the upper partition. A read of the limit address by upper-partition code returns the flash byte.
- R3: A table read (tbl_rd_en high, ifetch_en low) whose exec_pc is in the upper partition and whose tbl_rd_addr is in the lower partition returns rdata = 0x00 in the return cycle, which is RD_LAT cycles after the strobe.
- R4: A cycle with ifetch_en high is an instruction fetch and is never blocked, even if tbl_rd_en is also high. Its return cycle carries the flash byte and no violation.
- R5: A table read whose exec_pc is in the lower partition returns the flash byte for any target address in either partition.
- R6: With sec_limit = 0x00 the limit is 0x0000, and every read from every requester returns the flash byte.
- R7: The partitions of the requester and the target, and the limit, are all taken in the strobe cycle. Changes to exec_pc or sec_limit afterwards do not alter that read's result.
- R8: sec_limit = 0xFF is an ordinary value that puts the limit at 0xFF00. Code at 0xFF00 cannot read 0xFEFF, and code at 0xFEFF can read anything.
- R9: rd_violation is high for exactly one cycle, the return cycle of each blocked read, and low in every other cycle.
- R10: In any cycle without a violation, rdata equals flash_rdata in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_pc | input | 16 | Address of the instruction currently executing |
| tbl_rd_en | input | 1 | Table-read strobe |
| tbl_rd_addr | input | 16 | Code address of the table read |
| ifetch_en | input | 1 | Instruction-fetch strobe |
| sec_limit | input | 8 | Read-limit security byte (upper byte of the limit address) |
| flash_rdata | input | 8 | Raw byte from the flash array, valid RD_LAT cycles after a strobe |
| rdata | output | 8 | Guarded byte returned to the requester |
| rd_violation | output | 1 | One-cycle pulse when a returned byte was blanked |

## Verification
On every cycle, the assertions check four things:
- a violation always comes with zero data;
- a cycle without a violation passes flash_rdata straight through;
- a strobe from upper-partition code aimed at the lower partition always produces a violation one cycle later;
- fetches, lower-partition requesters and a zero limit never produce one.

Only the bench scenarios can show the remaining behaviour. This covers latching the requester when exec_pc and sec_limit change after the strobe, the exact boundary at the limit address, the 0xFF limit, and back-to-back reads where a blocked read is followed immediately by a permitted one.

// File: rtl/crg_pkg.sv
// Package: shared widths and the per-request record carried from the strobe
// cycle to the data-return cycle.
// Assumes a byte-wide flash and a limit byte that forms the upper address bits.
package crg_pkg;
    localparam int ADDR_W  = 16;
    localparam int LIMIT_W = 8;
    localparam int DATA_W  = 8;

    // Decision inputs captured when a request is issued.
    typedef struct packed {
        logic is_table_read; // data read of code memory, not a fetch
        logic req_upper;     // requester executes in the upper partition
        logic tgt_lower;     // target address lies in the lower partition
    } req_slot_t;
endpackage

// File: rtl/crg_partition.sv
// Module: crg_partition
// Classifies one address against the limit: the address is in the upper
// partition when its top LIMIT_W bits are at or above the limit byte.
// Assumes LIMIT_W <= ADDR_W; the low bits only set the 2^(ADDR_W-LIMIT_W) step.
module crg_partition #(
    parameter int ADDR_W  = 16,
    parameter int LIMIT_W = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LIMIT_W-1:0] limit,
    output logic               is_upper
);
    localparam int TOP = ADDR_W - 1;

    logic [LIMIT_W-1:0] addr_hi;

    // Pick out the address bits that line up with the limit byte.
    always_comb begin
        addr_hi = addr[TOP -: LIMIT_W];
    end

    // The limit address itself counts as upper (inclusive compare).
    always_comb begin
        is_upper = (addr_hi >= limit);
    end
endmodule

// File: rtl/crg_req_pipe.sv
// Module: crg_req_pipe
// Delays the request record by LAT cycles so that it lines up with the flash
// return data. Assumes the flash returns data exactly LAT cycles after a strobe
// and accepts at most one request per cycle.
module crg_req_pipe
    import crg_pkg::*;
#(
    parameter int LAT = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  req_slot_t slot_in,
    output req_slot_t slot_out
);
    localparam int LAST = LAT - 1;

    req_slot_t stage [LAT];

    // The first stage captures the record issued in the strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= slot_in;
    end

    // Any further stages just shift the record along.
    for (genvar g = 1; g < LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= stage[g-1];
        end
    end

    // Present the record that belongs to the data now returning.
    always_comb begin
        slot_out = stage[LAST];
    end
endmodule

// File: rtl/crg_return_mux.sv
// Module: crg_return_mux
// Return-path gate: blanks the flash byte and raises the violation flag when
// the aligned record describes an upper-to-lower table read. It is purely
// combinational, so the return path gains no latency.
module crg_return_mux
    import crg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  req_slot_t         slot,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] data_out,
    output logic              violation
);
    logic blank;

    // Only a table read from upper code aimed at lower memory is blanked.
    always_comb begin
        blank = slot.is_table_read & slot.req_upper & slot.tgt_lower;
    end

    // Substitute zero for the blocked byte; otherwise pass it through.
    always_comb begin
        data_out  = blank ? '0 : raw;
        violation = blank;
    end
endmodule

// File: rtl/code_read_guard.sv
// Module: code_read_guard (top)
// Read-limit guard between the processor's code port and the flash array.
// The requester's and the target's partitions are judged in the strobe cycle
// and carried RD_LAT cycles to the return, where a disallowed table read gets
// 0x00 and a one-cycle violation pulse. Fetches always pass.
// Assumes flash data arrives RD_LAT cycles after a strobe.
module code_read_guard #(
    parameter int RD_LAT = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] exec_pc,
    input  logic        tbl_rd_en,
    input  logic [15:0] tbl_rd_addr,
    input  logic        ifetch_en,
    input  logic [7:0]  sec_limit,
    input  logic [7:0]  flash_rdata,
    output logic [7:0]  rdata,
    output logic        rd_violation
);
    import crg_pkg::*;

    logic      pc_upper;
    logic      tgt_upper;
    req_slot_t issue_slot;
    req_slot_t ret_slot;

    // Classify the executing instruction's address.
    crg_partition #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_pc_part (
        .addr     (exec_pc),
        .limit    (sec_limit),
        .is_upper (pc_upper)
    );

    // Classify the table-read target address.
    crg_partition #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_tgt_part (
        .addr     (tbl_rd_addr),
        .limit    (sec_limit),
        .is_upper (tgt_upper)
    );

    // Build the request record; a fetch strobe overrides a table read.
    always_comb begin
        issue_slot.is_table_read = tbl_rd_en & ~ifetch_en;
        issue_slot.req_upper     = pc_upper;
        issue_slot.tgt_lower     = ~tgt_upper;
    end

    crg_req_pipe #(.LAT(RD_LAT)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_in  (issue_slot),
        .slot_out (ret_slot)
    );

    crg_return_mux #(.DATA_W(DATA_W)) u_mux (
        .slot      (ret_slot),
        .raw       (flash_rdata),
        .data_out  (rdata),
        .violation (rd_violation)
    );

    // A violation always returns an all-zero byte.
    assert_zero_on_violation_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_violation |-> (rdata == 8'h00));

    // Without a violation the flash byte passes through in the same cycle.
    assert_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_violation |-> (rdata == flash_rdata));

    if (RD_LAT == 1) begin : g_lat1_checks
        // An upper-to-lower table read is always flagged in its return cycle.
        assert_block_upper_to_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (tbl_rd_en && !ifetch_en && exec_pc[15:8] >= sec_limit
             && tbl_rd_addr[15:8] < sec_limit) |=> rd_violation);

        // A fetch never produces a violation.
        assert_fetch_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ifetch_en |=> !rd_violation);

        // A lower-partition requester is never restricted.
        assert_lower_unrestricted_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (exec_pc[15:8] < sec_limit) |=> !rd_violation);

        // A zero limit leaves everything readable.
        assert_zero_limit_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (sec_limit == 8'h00) |=> !rd_violation);

        // A violation is only ever the return of a read strobed one cycle earlier.
        assert_violation_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !tbl_rd_en |=> !rd_violation);
    end
endmodule

// File: tb/code_read_guard_tb.sv
module code_read_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] exec_pc = '0;
    logic        tbl_rd_en = 1'b0;
    logic [15:0] tbl_rd_addr = '0;
    logic        ifetch_en = 1'b0;
    logic [7:0]  sec_limit = '0;
    logic [7:0]  flash_rdata = '0;
    logic [7:0]  rdata;
    logic        rd_violation;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    code_read_guard #(.RD_LAT(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .exec_pc(exec_pc), .tbl_rd_en(tbl_rd_en),
        .tbl_rd_addr(tbl_rd_addr), .ifetch_en(ifetch_en), .sec_limit(sec_limit),
        .flash_rdata(flash_rdata), .rdata(rdata), .rd_violation(rd_violation)
    );

    task automatic check(string req, logic [7:0] exp_d, logic exp_v);
        checks++;
        if (rdata !== exp_d || rd_violation !== exp_v) begin
            fails++;
            $display("FAIL %s: rdata=%h viol=%b expected rdata=%h viol=%b",
                     req, rdata, rd_violation, exp_d, exp_v);
        end
    endtask

    // Issue one request, return flash byte in the next cycle, check the result.
    task automatic one_read(string req, logic [15:0] pc, logic [15:0] addr,
                            logic [7:0] lim, logic fetch, logic tread,
                            logic [7:0] fdata, logic blocked);
        @(negedge clk);
        exec_pc = pc; tbl_rd_addr = addr; sec_limit = lim;
        tbl_rd_en = tread; ifetch_en = fetch;
        @(negedge clk);
        tbl_rd_en = 1'b0; ifetch_en = 1'b0; flash_rdata = fdata;
        #1 check(req, blocked ? 8'h00 : fdata, blocked);
    endtask

    task automatic test_reset();
        @(negedge clk);
        flash_rdata = 8'h5A;
        #1 check("R9 reset", 8'h5A, 1'b0);
    endtask

    task automatic test_boundary();
        one_read("R3 upper->lower", 16'h4100, 16'h3FFF, 8'h40, 0, 1, 8'hA5, 1);
        one_read("R2 limit inclusive", 16'h4100, 16'h4000, 8'h40, 0, 1, 8'hA5, 0);
        one_read("R1 step 256", 16'h40FF, 16'h3F00, 8'h40, 0, 1, 8'h3C, 1);
        one_read("R1 requester at limit", 16'h4000, 16'h0000, 8'h40, 0, 1, 8'h77, 1);
    endtask

    task automatic test_lower_requester();
        one_read("R5 lower->lower", 16'h3FFF, 16'h0000, 8'h40, 0, 1, 8'h11, 0);
        one_read("R5 lower->upper", 16'h3FFF, 16'hFFFF, 8'h40, 0, 1, 8'h22, 0);
    endtask

    task automatic test_zero_limit();
        one_read("R6 zero limit low", 16'hFFFF, 16'h0000, 8'h00, 0, 1, 8'h99, 0);
        one_read("R6 zero limit high", 16'h8000, 16'h1234, 8'h00, 0, 1, 8'h98, 0);
    endtask

    task automatic test_ff_limit();
        one_read("R8 FF upper->lower", 16'hFF00, 16'hFEFF, 8'hFF, 0, 1, 8'hC3, 1);
        one_read("R8 FF lower req", 16'hFEFF, 16'h0000, 8'hFF, 0, 1, 8'hC4, 0);
        one_read("R8 FF upper->upper", 16'hFF10, 16'hFF00, 8'hFF, 0, 1, 8'hC5, 0);
    endtask

    task automatic test_fetch();
        one_read("R4 fetch into lower", 16'h8000, 16'h0010, 8'h40, 1, 0, 8'hE1, 0);
        one_read("R4 fetch with read strobe", 16'h8000, 16'h0010, 8'h40, 1, 1, 8'hE2, 0);
    endtask

    // The decision must use the strobe-cycle PC and limit, not later values.
    task automatic test_latch();
        @(negedge clk);
        exec_pc = 16'h9000; tbl_rd_addr = 16'h0100; sec_limit = 8'h80; tbl_rd_en = 1'b1;
        @(negedge clk);
        tbl_rd_en = 1'b0; exec_pc = 16'h0000; sec_limit = 8'h00; flash_rdata = 8'h66;
        #1 check("R7 latched blocked", 8'h00, 1'b1);
        @(negedge clk);
        exec_pc = 16'h1000; tbl_rd_addr = 16'h0100; sec_limit = 8'h80; tbl_rd_en = 1'b1;
        @(negedge clk);
        tbl_rd_en = 1'b0; exec_pc = 16'hF000; flash_rdata = 8'h67;
        #1 check("R7 latched allowed", 8'h67, 1'b0);
    endtask

    // Blocked then allowed back to back: violation lasts exactly one cycle.
    task automatic test_back_to_back();
        @(negedge clk);
        sec_limit = 8'h40; exec_pc = 16'h5000; tbl_rd_addr = 16'h0200; tbl_rd_en = 1'b1;
        @(negedge clk);
        flash_rdata = 8'h11; exec_pc = 16'h5000; tbl_rd_addr = 16'h6000;
        #1 check("R9 first blocked", 8'h00, 1'b1);
        @(negedge clk);
        tbl_rd_en = 1'b0; flash_rdata = 8'h22;
        #1 check("R9 second allowed", 8'h22, 1'b0);
        @(negedge clk);
        flash_rdata = 8'h33;
        #1 check("R10 idle passthrough", 8'h33, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        test_reset();
        test_boundary();
        test_lower_requester();
        test_zero_limit();
        test_ff_limit();
        test_fetch();
        test_latch();
        test_back_to_back();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule